// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block turns the CPU bus of an 8-bit banked home computer into memory chip selects. Software writes one byte to I/O port 0x00. That byte sets a mode bit, a 3-bit ROM page and a 4-bit RAM page. The block then uses this paging state, the upper CPU address bits and the memory request and read strobes to drive two ROM enables, a DRAM select and one upper DRAM address line. All of these are active-low except the address line.

In mode 0 the lowest 16KB holds ROM and one 16KB RAM page is remapped. In mode 1 the ROMs are switched out and a flat RAM map is used. A build-time parameter picks one of three configurations: a 16KB + 8KB ROM pair with 64KB DRAM, three 8KB ROMs with 64KB DRAM, or the ROM pair with 256KB DRAM. In the 256KB configuration the upper address output carries a bit multiplexed by the DRAM row/column phase input.

Top module: `mem_page_decoder`

## Requirements
- R1: An I/O write whose address low byte is 0x00 loads the paging byte, laid out as mode in bit 7, ROM page in bits 6:4 and RAM page in bits 3:0. Reset clears the byte to 0x00. I/O reads of port 0x00, and writes to any other low byte, leave the paging state unchanged. The upper address byte is not decoded.
- R2: The ROM enables and the RAM select stay high while the memory request is high. The ROM enables also stay high while the read strobe is high.
- R3: In mode 0, a memory read of 0x0000–0x1FFF drives the fixed-ROM enable (rom_a_no) low.
- R4: In the two-ROM configurations, a mode-0 read of 0x2000–0x3FFF drives rom_a_no low for ROM page 0 and rom_b_no low for ROM pages 1 and 7. All other ROM pages leave both enables high.
- R5: In the three-ROM configuration, rom_a_no covers only 0x0000–0x1FFF. A mode-0 read of 0x2000–0x3FFF drives rom_b_no low for ROM pages 0, 1 and 7.
- R6: In mode 1 neither ROM enable is ever driven low.
- R7: In the 64KB configurations, during a memory request ram_sel_no is low in any of these cases: the address is 0xC000–0xFFFF; mode 1 with RAM page 0; mode 0 with RAM page 0 at 0x4000–0x7FFF; mode 0 with RAM page 0 or 1 at 0x8000–0xBFFF.
- R8: In the 64KB configurations, dram_a_hi_o follows CPU A15. The exception is mode 0 with RAM page 1 at 0x8000–0xBFFF, where it is forced low.
- R9: In the 256KB configuration, the mode-1 RAM term covers RAM pages 0 to 3 (both upper page bits zero). All other RAM select terms are as in R7.
- R10: In the 256KB configuration, dram_a_hi_o is low when (RAM page bit 0 AND mpx_i) or (A15 AND A14), and high otherwise.
- R11: All four outputs are combinational from the paging state and the bus inputs, valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (write data) |
| mreq_ni | input | 1 | Memory request, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| mpx_i | input | 1 | DRAM row/column phase |
| rom_a_no | output | 1 | Fixed ROM / page-0 ROM enable, active low |
| rom_b_no | output | 1 | Paged ROM enable, active low |
| ram_sel_no | output | 1 | DRAM select, active low |
| dram_a_hi_o | output | 1 | Remapped upper DRAM address line |

## Verification
The hardest cases are the paging-state values that reach only one product term. Examples are ROM page 7 in the upper ROM window, RAM page 1 in the 0x8000 quadrant in mode 0, and RAM pages 2 and 3 in mode 1 of the 256KB build. Each needs a register write followed by an access in the right quadrant with the right strobe levels. The stimulus therefore writes all 256 paging values in turn. After each write it visits every 8KB region under each strobe combination and both MPX phases. A seeded random phase then mixes page writes with arbitrary addresses. Directed accesses to port 0x01, I/O reads of port 0x00 and a port-0x00 write with a nonzero upper address byte show the paging state is untouched or loaded as required.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;
  typedef enum logic [1:0] {
    CFG_R2_D64  = 2'd0,
    CFG_R3_D64  = 2'd1,
    CFG_R2_D256 = 2'd2
  } cfg_e;

  localparam int unsigned PAGE_W   = 8;
  localparam int unsigned ROMPG_W  = 3;
  localparam int unsigned RAMPG_W  = 4;

  typedef struct packed {
    logic                 relmode;
    logic [ROMPG_W-1:0]   rom_pg;
    logic [RAMPG_W-1:0]   ram_pg;
  } page_t;
endpackage

// File: rtl/page_reg.sv
module page_reg
  import mem_dec_pkg::*;
#(
  parameter int unsigned IO_W = 8,
  parameter logic [IO_W-1:0] PORT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_W-1:0]  io_addr_i,
  input  logic             iorq_ni,
  input  logic             wr_ni,
  input  logic [PAGE_W-1:0] wdata_i,
  output page_t            page_o
);
  logic ld;
  assign ld = !iorq_ni && !wr_ni && (io_addr_i == PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  page_o <= '0;
    else if (ld)  page_o <= page_t'(wdata_i);
  end
endmodule

// File: rtl/rom_decode.sv
module rom_decode
  import mem_dec_pkg::*;
#(
  parameter cfg_e CFG = CFG_R2_D64
) (
  input  page_t      page_i,
  input  logic [2:0] a_top_i,  // A15..A13
  input  logic       mreq_ni,
  input  logic       rd_ni,
  output logic       rom_a_no,
  output logic       rom_b_no
);
  logic rd_ok, fixed_win, paged_win, pg0, pg1, pg7;

  assign rd_ok     = !mreq_ni && !rd_ni && !page_i.relmode;
  assign fixed_win = rd_ok && (a_top_i == 3'b000);
  assign paged_win = rd_ok && (a_top_i == 3'b001);
  assign pg0       = (page_i.rom_pg == 3'd0);
  assign pg1       = (page_i.rom_pg == 3'd1);
  assign pg7       = (page_i.rom_pg == 3'd7);

  generate
    if (CFG == CFG_R3_D64) begin : g_three
      assign rom_a_no = !fixed_win;
      assign rom_b_no = !(paged_win && (pg0 || pg1 || pg7));
    end else begin : g_two
      // 16KB part spans fixed window plus page 0 of the paged window
      assign rom_a_no = !(fixed_win || (paged_win && pg0));
      assign rom_b_no = !(paged_win && (pg1 || pg7));
    end
  endgenerate
endmodule

// File: rtl/ram_decode.sv
module ram_decode
  import mem_dec_pkg::*;
#(
  parameter cfg_e CFG = CFG_R2_D64
) (
  input  page_t page_i,
  input  logic  a15_i,
  input  logic  a14_i,
  input  logic  mreq_ni,
  input  logic  mpx_i,
  output logic  ram_sel_no,
  output logic  dram_a_hi_o
);
  logic top_q, q1, q2, pz, p01, m1_term, act;

  assign top_q = a15_i && a14_i;
  assign q1    = !a15_i && a14_i;
  assign q2    = a15_i && !a14_i;
  assign pz    = (page_i.ram_pg == '0);
  assign p01   = (page_i.ram_pg[RAMPG_W-1:1] == '0);

  generate
    if (CFG == CFG_R2_D256) begin : g_big
      assign m1_term     = page_i.relmode && (page_i.ram_pg[RAMPG_W-1:RAMPG_W-2] == '0);
      assign dram_a_hi_o = !((page_i.ram_pg[0] && mpx_i) || top_q);
    end else begin : g_small
      logic remap;
      assign m1_term     = page_i.relmode && pz;
      // mode-0 page 1 in 0x8000 quadrant lands on DRAM 0x0000
      assign remap       = !page_i.relmode && (page_i.ram_pg == 4'd1) && q2;
      assign dram_a_hi_o = !(!a15_i || remap);
    end
  endgenerate

  assign act = !mreq_ni && (top_q || m1_term ||
               (!page_i.relmode && pz && q1) ||
               (!page_i.relmode && p01 && q2));
  assign ram_sel_no = !act;
endmodule

// File: rtl/mem_page_decoder.sv
module mem_page_decoder
  import mem_dec_pkg::*;
#(
  parameter cfg_e        CFG    = CFG_R2_D64,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IO_W   = 8,
  parameter logic [IO_W-1:0] PAGE_PORT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              mreq_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              mpx_i,
  output logic              rom_a_no,
  output logic              rom_b_no,
  output logic              ram_sel_no,
  output logic              dram_a_hi_o
);
  localparam int unsigned A15 = ADDR_W - 1;
  localparam int unsigned A14 = ADDR_W - 2;
  localparam int unsigned A13 = ADDR_W - 3;

  page_t page_q;

  page_reg #(.IO_W(IO_W), .PORT(PAGE_PORT)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .io_addr_i(addr_i[IO_W-1:0]),
    .iorq_ni  (iorq_ni),
    .wr_ni    (wr_ni),
    .wdata_i  (data_i),
    .page_o   (page_q)
  );

  rom_decode #(.CFG(CFG)) u_rom (
    .page_i  (page_q),
    .a_top_i (addr_i[A15:A13]),
    .mreq_ni (mreq_ni),
    .rd_ni   (rd_ni),
    .rom_a_no(rom_a_no),
    .rom_b_no(rom_b_no)
  );

  ram_decode #(.CFG(CFG)) u_ram (
    .page_i     (page_q),
    .a15_i      (addr_i[A15]),
    .a14_i      (addr_i[A14]),
    .mreq_ni    (mreq_ni),
    .mpx_i      (mpx_i),
    .ram_sel_no (ram_sel_no),
    .dram_a_hi_o(dram_a_hi_o)
  );
endmodule

// File: rtl/mem_page_decoder_chk.sv
module mem_page_decoder_chk
  import mem_dec_pkg::*;
#(
  parameter cfg_e        CFG    = CFG_R2_D64,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IO_W   = 8,
  parameter logic [IO_W-1:0] PAGE_PORT = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_i,
  input logic              mreq_ni,
  input logic              iorq_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic              rom_a_no,
  input logic              rom_b_no,
  input logic              ram_sel_no,
  input logic              dram_a_hi_o,
  input page_t             page_i
);
  logic wr_hit;
  assign wr_hit = !iorq_ni && !wr_ni && (addr_i[IO_W-1:0] == PAGE_PORT);

  // R1
  page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (page_i == $past(data_i)));
  // R1
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(page_i));
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> (rom_a_no && rom_b_no && ram_sel_no));
  // R2
  rom_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> (rom_a_no && rom_b_no));
  // R3
  fixed_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && !rd_ni && !page_i.relmode && addr_i[ADDR_W-1 -: 3] == 3'b000) |-> !rom_a_no);
  // R6
  mode1_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_i.relmode |-> (rom_a_no && rom_b_no));
  // R7
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!rom_a_no, !rom_b_no, !ram_sel_no}) <= 1);

  generate
    if (CFG == CFG_R2_D256) begin : g_big
      // R10
      hi_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i[ADDR_W-1] && addr_i[ADDR_W-2]) |-> !dram_a_hi_o);
    end else begin : g_small
      // R8
      hi_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_i[ADDR_W-1] |-> !dram_a_hi_o);
    end
  endgenerate
endmodule

bind mem_page_decoder mem_page_decoder_chk #(
  .CFG(CFG), .ADDR_W(ADDR_W), .IO_W(IO_W), .PAGE_PORT(PAGE_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
  .mreq_ni(mreq_ni), .iorq_ni(iorq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .rom_a_no(rom_a_no), .rom_b_no(rom_b_no), .ram_sel_no(ram_sel_no),
  .dram_a_hi_o(dram_a_hi_o), .page_i(page_q)
);

// File: tb/sim_mem_page_decoder.sv
module sim_mem_page_decoder;
  import mem_dec_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mpx = 1'b0;
  logic [3:0] o0, o1, o2;
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] page_m = '0;  // bench model of the paging byte

  always #5 clk = ~clk;

  mem_page_decoder #(.CFG(CFG_R2_D64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .mreq_ni(mreq_n),
    .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .mpx_i(mpx),
    .rom_a_no(o0[3]), .rom_b_no(o0[2]), .ram_sel_no(o0[1]), .dram_a_hi_o(o0[0]));
  mem_page_decoder #(.CFG(CFG_R3_D64)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .mreq_ni(mreq_n),
    .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .mpx_i(mpx),
    .rom_a_no(o1[3]), .rom_b_no(o1[2]), .ram_sel_no(o1[1]), .dram_a_hi_o(o1[0]));
  mem_page_decoder #(.CFG(CFG_R2_D256)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .mreq_ni(mreq_n),
    .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .mpx_i(mpx),
    .rom_a_no(o2[3]), .rom_b_no(o2[2]), .ram_sel_no(o2[1]), .dram_a_hi_o(o2[0]));

  // {rom_a_n, rom_b_n, ram_n, dram_hi}
  function automatic logic [3:0] ref_out(int cfg, logic [7:0] pg, logic [15:0] a,
                                          logic mq, logic rd, logic mx);
    logic m, a15, a14, rok, fix, win, aa, bb, m1, ra, hi;
    logic [2:0] r;
    logic [3:0] p;
    m = pg[7]; r = pg[6:4]; p = pg[3:0]; a15 = a[15]; a14 = a[14];
    rok = !mq && !rd && !m;
    fix = rok && (a[15:13] == 3'b000);
    win = rok && (a[15:13] == 3'b001);
    if (cfg == 1) begin
      aa = fix; bb = win && (r == 0 || r == 1 || r == 7);
    end else begin
      aa = fix || (win && r == 0); bb = win && (r == 1 || r == 7);
    end
    m1 = m && ((cfg == 2) ? (p[3:2] == 2'b00) : (p == 4'd0));
    ra = !mq && ((a15 && a14) || m1 || (!m && p == 0 && !a15 && a14) ||
                 (!m && p <= 1 && a15 && !a14));
    if (cfg == 2) hi = !((p[0] && mx) || (a15 && a14));
    else          hi = a15 && !(!m && p == 1 && !a14);
    return {!aa, !bb, !ra, hi};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b page=%h addr=%h mreq_n=%b rd_n=%b mpx=%b",
               tag, act, exp, page_m, addr, mreq_n, rd_n, mpx);
    end
  endtask

  task automatic cmp_all();
    logic [3:0] e;
    #1;
    e = ref_out(0, page_m, addr, mreq_n, rd_n, mpx);
    chk("R3 cfg0 rom_a", o0[3], e[3]); chk("R4 cfg0 rom_b", o0[2], e[2]);
    chk("R7 cfg0 ram", o0[1], e[1]);   chk("R8 cfg0 hi", o0[0], e[0]);
    e = ref_out(1, page_m, addr, mreq_n, rd_n, mpx);
    chk("R5 cfg1 rom_a", o1[3], e[3]); chk("R5 cfg1 rom_b", o1[2], e[2]);
    chk("R7 cfg1 ram", o1[1], e[1]);   chk("R8 cfg1 hi", o1[0], e[0]);
    e = ref_out(2, page_m, addr, mreq_n, rd_n, mpx);
    chk("R4 cfg2 rom_a", o2[3], e[3]); chk("R4 cfg2 rom_b", o2[2], e[2]);
    chk("R9 cfg2 ram", o2[1], e[1]);   chk("R10 cfg2 hi", o2[0], e[0]);
  endtask

  task automatic io_cycle(logic [15:0] a, logic [7:0] d, logic is_wr);
    @(negedge clk);
    mreq_n = 1'b1; addr = a; data = d; iorq_n = 1'b0;
    wr_n = !is_wr; rd_n = is_wr;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    if (is_wr && a[7:0] == 8'h00) page_m = d;
  endtask

  task automatic mem_rd(logic [15:0] a);
    mreq_n = 1'b0; rd_n = 1'b0; addr = a; mpx = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #23 rst_n = 1'b1;
    // R1 reset state: page 0, mode 0 -> fixed ROM on read of 0x0000
    @(negedge clk); mem_rd(16'h0000); #1;
    chk("R1 reset rom_a", o0[3], 1'b0);
    chk("R1 reset rom_a", o1[3], 1'b0);
    mem_rd(16'h4000); #1;
    chk("R1 reset ram page0 q1", o0[1], 1'b0);
    mreq_n = 1'b1; rd_n = 1'b1;

    // R1 load, then ignored accesses
    io_cycle(16'h0000, 8'h81, 1'b1);
    mem_rd(16'h0000); #1;
    chk("R1 load mode1 rom_a", o0[3], 1'b1);
    chk("R6 mode1 rom_a", o1[3], 1'b1);
    mreq_n = 1'b1; rd_n = 1'b1;
    io_cycle(16'h0001, 8'h00, 1'b1);   // other port
    mem_rd(16'h0000); #1;
    chk("R1 other port ignored", o0[3], 1'b1);
    mreq_n = 1'b1; rd_n = 1'b1;
    data = 8'h00;
    io_cycle(16'h0000, 8'h00, 1'b0);   // I/O read of port 0
    mem_rd(16'h4000); #1;
    chk("R1 port read ignored ram", o0[1], 1'b1);   // mode1 page1 -> no RAM at 0x4000
    chk("R1 port read ignored rom", o0[3], 1'b1);
    mreq_n = 1'b1; rd_n = 1'b1;
    io_cycle(16'h7F00, 8'h10, 1'b1);   // high byte not decoded
    mem_rd(16'h2000); #1;
    chk("R1 upper byte ignored rom_b", o0[2], 1'b0);
    // R2 strobes
    rd_n = 1'b1; #1;
    chk("R2 rd high rom_b", o0[2], 1'b1);
    mreq_n = 1'b1; rd_n = 1'b0; addr = 16'hC000; #1;
    chk("R2 mreq high ram", o0[1], 1'b1);
    chk("R2 mreq high rom", o0[2], 1'b1);
    mreq_n = 1'b1; rd_n = 1'b1;

    // Full sweep of every paging byte
    for (int pv = 0; pv < 256; pv++) begin
      io_cycle(16'h0000, pv[7:0], 1'b1);
      for (int rg = 0; rg < 8; rg++) begin
        for (int st = 0; st < 3; st++) begin
          for (int mx = 0; mx < 2; mx++) begin
            addr = {rg[2:0], 13'h0155};
            mreq_n = (st == 2); rd_n = (st == 1); mpx = mx[0];
            cmp_all();
          end
        end
      end
      mreq_n = 1'b1; rd_n = 1'b1;
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0) begin
        mreq_n = 1'b1; rd_n = 1'b1;
        io_cycle({8'($urandom), 8'h00}, 8'($urandom), 1'b1);
      end
      addr = 16'($urandom);
      mreq_n = ($urandom % 4 == 0); rd_n = ($urandom % 4 == 0);
      mpx = 1'($urandom);
      cmp_all();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule